// File: doc/BRIEF.md
# Banked Process Context Register

This block is one system-control register that names the running process. It holds a 24-bit process number and an 8-bit address-space tag. There are two copies of it, one for each security world. The core reaches the register through coprocessor-style accesses, which carry four selector fields. The block answers only the single selector combination that names it and ignores every other combination.

A privileged access reads or writes the copy that belongs to the current security world. An access from user level is refused: the block raises an undefined-instruction indication and changes neither copy. The address-space tag of the active world is driven out continuously, so the translation unit and the debug comparators can use it. Every write that the block accepts also requests a global flush of the branch-target cache for one cycle.

Top module: `ctxid_reg_banked`

## Requirements
- R1: The block responds only when `op1`=0, `crn`=13, `crm`=0 and `op2`=1. Any other access raises no undefined indication and no flush, changes no copy, and returns zero read data.
- R2: A privileged access with `secure`=1 reads or writes only the secure copy.
- R3: A privileged access with `secure`=0 reads or writes only the non-secure copy.
- R4: A matching access with `priv`=0, read or write, drives `undef_o` high in the same cycle as the access and leaves both copies unchanged.
- R5: Every accepted write (matching, privileged, `acc_wr`=1) drives `flush_o` high for exactly the one cycle after the write's clock edge. A write refused under R4 produces no flush.
- R6: After reset both copies read as zero, `asid_o` is zero and `flush_o` is low.
- R7: `asid_o` equals bits [7:0] of the copy selected by `secure`. It follows a change of `secure` in the same cycle, and it shows a newly written value from the cycle after the write edge.
- R8: The register is 32 bits wide: bits [31:8] hold the process number and bits [7:0] hold the address-space tag. A read returns all 32 bits exactly as they were last written.
- R9: `rd_data_o` is zero in every cycle that has no matching privileged read. During such a read it shows the selected copy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_op1 | input | 3 | First opcode selector |
| acc_crn | input | 4 | Primary register selector |
| acc_crm | input | 4 | Secondary register selector |
| acc_op2 | input | 3 | Second opcode selector |
| acc_wdata | input | 32 | Write data |
| priv | input | 1 | 1 = privileged mode |
| secure | input | 1 | 1 = secure world |
| rd_data_o | output | 32 | Read data, combinational |
| undef_o | output | 1 | Undefined-instruction indication |
| flush_o | output | 1 | Global branch-target-cache flush pulse |
| asid_o | output | 8 | Address-space tag of the active world |

## Verification
Read data, the undefined indication and `asid_o` are combinational, so their results are due in the cycle of the stimulus itself. The bench samples them 1 ns after it drives inputs on the falling edge. The flush pulse and any write pass through one register, so the bench checks them at the next falling edge. It checks again at the falling edge after that, where the pulse must have ended. After each access the bench toggles `secure` and compares `asid_o` against its model of both copies, which also confirms that the other copy was left unchanged.

// File: rtl/ctxid_pkg.sv
package ctxid_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ASID_W    = 8;
    localparam int unsigned PROC_W    = DATA_W - ASID_W;
    localparam int unsigned NUM_BANKS = 2;
    localparam int unsigned OP1_W     = 3;
    localparam int unsigned CR_W      = 4;
    localparam int unsigned OP2_W     = 3;

    localparam logic [OP1_W-1:0] SEL_OP1 = 3'd0;
    localparam logic [CR_W-1:0]  SEL_CRN = 4'd13;
    localparam logic [CR_W-1:0]  SEL_CRM = 4'd0;
    localparam logic [OP2_W-1:0] SEL_OP2 = 3'd1;

    typedef enum logic [0:0] {
        BANK_NS = 1'b0,
        BANK_S  = 1'b1
    } bank_e;

    typedef struct packed {
        logic [PROC_W-1:0] proc_id;
        logic [ASID_W-1:0] asid;
    } ctxid_t;

    typedef struct packed {
        logic  fault;
        logic  wr_ok;
        logic  rd_ok;
        bank_e bank;
    } acc_cls_t;

    function automatic logic sel_match(
        input logic [OP1_W-1:0] op1,
        input logic [CR_W-1:0]  crn,
        input logic [CR_W-1:0]  crm,
        input logic [OP2_W-1:0] op2
    );
        return (op1 == SEL_OP1) && (crn == SEL_CRN) &&
               (crm == SEL_CRM) && (op2 == SEL_OP2);
    endfunction

endpackage

// File: rtl/ctxid_decode.sv
module ctxid_decode
    import ctxid_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_wr,
    input  logic [OP1_W-1:0] acc_op1,
    input  logic [CR_W-1:0]  acc_crn,
    input  logic [CR_W-1:0]  acc_crm,
    input  logic [OP2_W-1:0] acc_op2,
    input  logic             priv,
    input  logic             secure,
    output acc_cls_t         cls
);
    logic hit;

    always_comb begin
        hit       = acc_valid && sel_match(acc_op1, acc_crn, acc_crm, acc_op2);
        cls.fault = hit && !priv;
        cls.wr_ok = hit && priv && acc_wr;
        cls.rd_ok = hit && priv && !acc_wr;
        cls.bank  = secure ? BANK_S : BANK_NS;
    end
endmodule

// File: rtl/ctxid_bank.sv
module ctxid_bank
    import ctxid_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  bank_e                      sel,
    input  ctxid_t                     wdata,
    output ctxid_t [NUM_BANKS-1:0]     q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ctxid_t r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (we && (int'(sel) == b))
                r <= wdata;
        end
        assign q[b] = r;

        // R2 / R3: a write lands only in the copy it selected
        a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
            (we && int'(sel) == b) |=> (q[b] == $past(wdata)));
        a_r3_other_kept: assert property (@(posedge clk) disable iff (rst)
            !(we && int'(sel) == b) |=> $stable(q[b]));
    end
endmodule

// File: rtl/ctxid_reg_banked.sv
module ctxid_reg_banked
    import ctxid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [2:0]        acc_op1,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op2,
    input  logic [31:0]       acc_wdata,
    input  logic              priv,
    input  logic              secure,
    output logic [31:0]       rd_data_o,
    output logic              undef_o,
    output logic              flush_o,
    output logic [7:0]        asid_o
);
    acc_cls_t               cls;
    ctxid_t [NUM_BANKS-1:0] q;
    ctxid_t                 sel_q;
    logic                   flush_q;

    ctxid_decode u_dec (
        .acc_valid (acc_valid),
        .acc_wr    (acc_wr),
        .acc_op1   (acc_op1),
        .acc_crn   (acc_crn),
        .acc_crm   (acc_crm),
        .acc_op2   (acc_op2),
        .priv      (priv),
        .secure    (secure),
        .cls       (cls)
    );

    ctxid_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cls.wr_ok),
        .sel   (cls.bank),
        .wdata (ctxid_t'(acc_wdata)),
        .q     (q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            flush_q <= 1'b0;
        else
            flush_q <= cls.wr_ok;
    end

    always_comb begin
        sel_q     = q[cls.bank];
        rd_data_o = cls.rd_ok ? DATA_W'(sel_q) : '0;
        undef_o   = cls.fault;
        flush_o   = flush_q;
        asid_o    = sel_q.asid;
    end

    // R4: a refused access leaves both copies as they were
    a_r4_fault_keeps_banks: assert property (@(posedge clk) disable iff (rst)
        undef_o |=> $stable(q));
    // R5: flush follows an accepted write, and only such a write
    a_r5_flush_after_write: assert property (@(posedge clk) disable iff (rst)
        cls.wr_ok |=> flush_o);
    a_r5_flush_has_cause: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> $past(cls.wr_ok));
    // R5 / R4: a refused write never flushes
    a_r5_no_flush_on_fault: assert property (@(posedge clk) disable iff (rst)
        (undef_o && acc_wr) |=> !flush_o);
    // R9: read data stays zero without a granted read
    a_r9_rdata_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_wr && priv) |-> (rd_data_o == '0));
    // R1: no refusal without the exact selector match
    a_r1_undef_needs_match: assert property (@(posedge clk) disable iff (rst)
        undef_o |-> (acc_valid && acc_crn == 4'd13 && acc_op2 == 3'd1));
endmodule

// File: tb/tb_ctxid_reg_banked.sv
module tb_ctxid_reg_banked;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_wr = 1'b0;
    logic [2:0]  acc_op1 = '0, acc_op2 = '0;
    logic [3:0]  acc_crn = '0, acc_crm = '0;
    logic [31:0] acc_wdata = '0;
    logic        priv = 1'b0, secure = 1'b0;
    logic [31:0] rd_data_o;
    logic        undef_o, flush_o;
    logic [7:0]  asid_o;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] m_s = '0, m_ns = '0;

    always #2.5 clk = ~clk;

    ctxid_reg_banked dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_match(logic [2:0] o1, logic [3:0] n, logic [3:0] m, logic [2:0] o2);
        return o1 == 3'd0 && n == 4'd13 && m == 4'd0 && o2 == 3'd1;
    endfunction

    task automatic check_asids();
        secure = 1'b1; #1 chk("R7 asid secure", {24'd0, asid_o}, {24'd0, m_s[7:0]});
        secure = 1'b0; #1 chk("R7 asid nonsecure", {24'd0, asid_o}, {24'd0, m_ns[7:0]});
    endtask

    task automatic access(bit wr, logic [2:0] o1, logic [3:0] n, logic [3:0] m,
                          logic [2:0] o2, logic [31:0] d, bit p, bit s);
        bit hit = is_match(o1, n, m, o2);
        bit acc = hit && p && wr;
        logic [31:0] exp_rd = (hit && p && !wr) ? (s ? m_s : m_ns) : 32'd0;
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = wr; acc_op1 = o1; acc_crn = n; acc_crm = m;
        acc_op2 = o2; acc_wdata = d; priv = p; secure = s;
        #1;
        chk(hit ? "R4 undef" : "R1 undef on mismatch", {31'd0, undef_o}, {31'd0, hit && !p});
        chk(s ? "R2/R9 read data" : "R3/R9 read data", rd_data_o, exp_rd);
        chk("R5 flush ended", {31'd0, flush_o}, 32'd0);
        @(negedge clk);
        acc_valid = 1'b0;
        if (acc) begin
            if (s) m_s = d; else m_ns = d;
        end
        #1 chk("R5 flush pulse", {31'd0, flush_o}, {31'd0, acc});
        check_asids();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk("R6 flush reset", {31'd0, flush_o}, 32'd0);
        check_asids();
        access(0, 0, 13, 0, 1, 0, 1, 1);   // R6 secure copy zero
        access(0, 0, 13, 0, 1, 0, 1, 0);   // R6 nonsecure copy zero
        // R2 / R8: full-width secure write and read back
        access(1, 0, 13, 0, 1, 32'hDEADBE5A, 1, 1);
        access(0, 0, 13, 0, 1, 0, 1, 1);
        // R3: nonsecure write does not disturb secure copy
        access(1, 0, 13, 0, 1, 32'h123456C3, 1, 0);
        access(0, 0, 13, 0, 1, 0, 1, 0);
        access(0, 0, 13, 0, 1, 0, 1, 1);
        // R4: user write refused, no flush, copies unchanged
        access(1, 0, 13, 0, 1, 32'hFFFFFFFF, 0, 1);
        access(0, 0, 13, 0, 1, 0, 0, 0);
        // R1: near-miss selectors ignored
        access(1, 1, 13, 0, 1, 32'h0BADF00D, 1, 1);
        access(1, 0, 12, 0, 1, 32'h0BADF00D, 1, 0);
        access(1, 0, 13, 1, 1, 32'h0BADF00D, 0, 1);
        access(0, 0, 13, 0, 0, 0, 1, 1);
        // R5: back-to-back writes each flush
        access(1, 0, 13, 0, 1, 32'h00000001, 1, 1);
        access(1, 0, 13, 0, 1, 32'h00000002, 1, 1);
        for (int i = 0; i < 400; i++) begin
            bit hit = ($urandom % 4) != 0;
            logic [2:0] o1 = hit ? 3'd0 : 3'($urandom);
            logic [3:0] n  = hit ? 4'd13 : 4'($urandom);
            logic [3:0] m  = hit ? 4'd0 : 4'($urandom);
            logic [2:0] o2 = hit ? 3'd1 : 3'($urandom);
            access(1'($urandom), o1, n, m, o2, $urandom, ($urandom % 4) != 0, 1'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule